// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Watermark Requests

This block sits between a serial audio shifter and the system bus. It holds one transmit FIFO and one receive FIFO of 16-bit samples. Bus writes fill the transmit FIFO, and the shifter drains it through a request/data handshake. The shifter fills the receive FIFO, and bus reads drain it. Each read returns the sample together with a valid flag.

Each direction has a programmable 6-bit watermark that drives a DMA request line. Each direction also reports its occupancy count and four level flags. Level and error events collect into twelve sticky status bits. Software clears these bits by writing ones to a clear port. A single pending output summarises the enabled status bits.

Top module: `audio_fifo_wm`

## Requirements
- R1: Each FIFO holds 32 words of 16 bits and returns them in the order they were pushed. A receive read returns the head sample in bits 15:0 and a valid flag in bit 16. When the receive FIFO is empty, bit 16 reads 0. The transmit side presents its head word on `tx_ser_data_o`, and `tx_ser_vld_o` is high while that FIFO is non-empty.
- R2: Each count output holds the occupancy, from 0 to 32. Each flag vector uses this layout: bit 0 is empty (count 0), bit 1 is almost-empty (count of 4 or less), bit 2 is full (count 32) and bit 3 is almost-full (count of 28 or more).
- R3: Control bit 0 is the global enable. Bit 2 enables the transmit FIFO and bit 1 enables the receive FIFO. A FIFO works only while both its own bit and the global bit are 1. Otherwise it is emptied, and it ignores pushes and pops without raising any event.
- R4: Control bits 18:13 hold the transmit watermark and bit 6 enables transmit DMA. `tx_dma_req_o` is high while the transmit FIFO works, transmit DMA is enabled and the count is at or below the watermark.
- R5: Control bits 12:7 hold the receive watermark and bit 5 enables receive DMA. `rx_dma_req_o` is high while the receive FIFO works, receive DMA is enabled and the count is at or above the watermark.
- R6: A push into a full FIFO is dropped and leaves the stored words unchanged. This holds even when a pop happens in the same cycle. The push sets the overflow status bit of that direction.
- R7: A pop request on an empty FIFO sets the starve status bit of that direction. For transmit, the pop request is the shifter request; for receive, it is the bus read.
- R8: The transmit status bits are 5:0 and the receive status bits are 11:6. Within each group the offsets are: 0 empty, 1 almost-empty, 2 full, 3 almost-full, 4 starve, 5 overflow. A level bit is set at the clock edge ending any cycle in which its flag is true and its FIFO works. All status bits are sticky.
- R9: A cycle with `clr_we_i` high clears every status bit whose position is 1 in `clr_mask_i`. If an event for the same bit occurs in that cycle, the set wins.
- R10: `irq_pend_o` is high exactly when `irq_glb_en_i` is 1 and at least one status bit is set whose enable bit in `irq_en_i` is also set. The enable bits use the same positions as the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 19 | Enables, DMA enables and watermarks |
| irq_en_i | input | 12 | Per-event interrupt enables |
| irq_glb_en_i | input | 1 | Global interrupt enable |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 12 | Status bits to clear |
| tx_wr_i | input | 1 | Bus push into transmit FIFO |
| tx_wdata_i | input | 16 | Transmit sample |
| tx_ser_req_i | input | 1 | Shifter pops a transmit word |
| tx_ser_data_o | output | 16 | Transmit head word |
| tx_ser_vld_o | output | 1 | Transmit head is valid |
| rx_ser_wr_i | input | 1 | Shifter pushes a receive word |
| rx_ser_data_i | input | 16 | Received sample |
| rx_rd_i | input | 1 | Bus pops a receive word |
| rx_rdata_o | output | 17 | Valid flag and receive head word |
| tx_cnt_o | output | 6 | Transmit occupancy |
| rx_cnt_o | output | 6 | Receive occupancy |
| tx_flags_o | output | 4 | Transmit level flags |
| rx_flags_o | output | 4 | Receive level flags |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive DMA request |
| irq_stat_o | output | 12 | Sticky event status |
| irq_pend_o | output | 1 | Interrupt pending |

## Verification
The assertions assume that the control word, pushes, pops and clears change only between clock edges. They also assume that the shifter and bus sides may push into a full FIFO or pop from an empty one at any time, since those cases are defined events and not protocol violations. The stimulus changes every input one time unit after a rising edge. It sweeps every fill level from 0 to 32 against all 64 watermark values, and every enable mask against a fixed status pattern. It drives pushes on full and pops on empty deliberately, so these events are exercised rather than avoided.

// File: rtl/audio_fifo_wm.sv
module audio_fifo_wm #(
  parameter int DW     = 16,
  parameter int DEPTH  = 32,
  parameter int AE_LVL = 4,
  parameter int AF_LVL = 28,
  parameter int WMW    = 6,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int NEV   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [18:0]       ctrl_i,
  input  logic [2*NEV-1:0]  irq_en_i,
  input  logic              irq_glb_en_i,
  input  logic              clr_we_i,
  input  logic [2*NEV-1:0]  clr_mask_i,
  input  logic              tx_wr_i,
  input  logic [DW-1:0]     tx_wdata_i,
  input  logic              tx_ser_req_i,
  output logic [DW-1:0]     tx_ser_data_o,
  output logic              tx_ser_vld_o,
  input  logic              rx_ser_wr_i,
  input  logic [DW-1:0]     rx_ser_data_i,
  input  logic              rx_rd_i,
  output logic [DW:0]       rx_rdata_o,
  output logic [CW-1:0]     tx_cnt_o,
  output logic [CW-1:0]     rx_cnt_o,
  output logic [3:0]        tx_flags_o,
  output logic [3:0]        rx_flags_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o,
  output logic [2*NEV-1:0]  irq_stat_o,
  output logic              irq_pend_o
);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [WMW-1:0] tx_wm, rx_wm;
  logic tx_act, rx_act, tx_empty, tx_full, rx_empty, rx_full;
  logic tx_push, tx_pop, rx_push, rx_pop;
  logic [2*NEV-1:0] ev, stat;

  assign tx_act = ctrl_i[0] & ctrl_i[2];
  assign rx_act = ctrl_i[0] & ctrl_i[1];
  assign tx_wm  = ctrl_i[18:13];
  assign rx_wm  = ctrl_i[12:7];

  assign tx_empty = (tx_cnt == '0);
  assign tx_full  = (tx_cnt == CW'(DEPTH));
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(DEPTH));

  assign tx_push = tx_act & tx_wr_i & ~tx_full;
  assign tx_pop  = tx_act & tx_ser_req_i & ~tx_empty;
  assign rx_push = rx_act & rx_ser_wr_i & ~rx_full;
  assign rx_pop  = rx_act & rx_rd_i & ~rx_empty;

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_act) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      tx_wp  <= tx_wp + AW'(tx_push);
      tx_rp  <= tx_rp + AW'(tx_pop);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_act) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      rx_wp  <= rx_wp + AW'(rx_push);
      rx_rp  <= rx_rp + AW'(rx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata_i;
    if (rx_push) rx_mem[rx_wp] <= rx_ser_data_i;
  end

  assign tx_ser_vld_o  = tx_act & ~tx_empty;
  assign tx_ser_data_o = tx_mem[tx_rp];
  assign rx_rdata_o    = (rx_act & ~rx_empty) ? {1'b1, rx_mem[rx_rp]} : '0;

  assign tx_cnt_o   = tx_cnt;
  assign rx_cnt_o   = rx_cnt;
  assign tx_flags_o = {int'(tx_cnt) >= AF_LVL, tx_full, int'(tx_cnt) <= AE_LVL, tx_empty};
  assign rx_flags_o = {int'(rx_cnt) >= AF_LVL, rx_full, int'(rx_cnt) <= AE_LVL, rx_empty};

  assign tx_dma_req_o = tx_act & ctrl_i[6] & (int'(tx_cnt) <= int'(tx_wm));
  assign rx_dma_req_o = rx_act & ctrl_i[5] & (int'(rx_cnt) >= int'(rx_wm));

  assign ev[3:0]  = {4{tx_act}} & tx_flags_o;
  assign ev[4]    = tx_act & tx_ser_req_i & tx_empty;
  assign ev[5]    = tx_act & tx_wr_i & tx_full;
  assign ev[9:6]  = {4{rx_act}} & rx_flags_o;
  assign ev[10]   = rx_act & rx_rd_i & rx_empty;
  assign ev[11]   = rx_act & rx_ser_wr_i & rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~(clr_we_i ? clr_mask_i : '0)) | ev;
  end

  assign irq_stat_o = stat;
  assign irq_pend_o = irq_glb_en_i & |(stat & irq_en_i);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt_o) <= DEPTH && int'(rx_cnt_o) <= DEPTH); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_flags_o[0] && tx_flags_o[2]) && !(rx_flags_o[0] && rx_flags_o[2])); // R2
  AST_DIS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[0] |=> tx_cnt_o == '0 && rx_cnt_o == '0); // R3
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && tx_wr_i && tx_full && !tx_ser_req_i) |=> (tx_cnt_o == CW'(DEPTH) && irq_stat_o[5])); // R6
  AST_STARVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_act && rx_rd_i && rx_empty) |=> irq_stat_o[10]); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((irq_stat_o & $past(irq_stat_o)) == $past(irq_stat_o))); // R8

endmodule

// File: tb/test_audio_fifo_wm.sv
`timescale 1ns/100ps
module test_audio_fifo_wm;
  logic clk = 0, rst_n = 0;
  logic [18:0] ctrl = '0;
  logic [11:0] irq_en = '0, clr_mask = '0;
  logic glb = 0, clr_we = 0;
  logic tx_wr = 0, tx_req = 0, rx_wr = 0, rx_rd = 0;
  logic [15:0] tx_wd = '0, rx_wd = '0, tx_sd;
  logic tx_sv, tx_dreq, rx_dreq, pend;
  logic [16:0] rx_rdata;
  logic [5:0] tx_cnt, rx_cnt;
  logic [3:0] tx_fl, rx_fl;
  logic [11:0] stat;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  audio_fifo_wm i_audio_fifo_wm (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .irq_en_i(irq_en), .irq_glb_en_i(glb),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wd),
    .tx_ser_req_i(tx_req), .tx_ser_data_o(tx_sd), .tx_ser_vld_o(tx_sv),
    .rx_ser_wr_i(rx_wr), .rx_ser_data_i(rx_wd), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .tx_cnt_o(tx_cnt), .rx_cnt_o(rx_cnt), .tx_flags_o(tx_fl), .rx_flags_o(rx_fl),
    .tx_dma_req_o(tx_dreq), .rx_dma_req_o(rx_dreq), .irq_stat_o(stat), .irq_pend_o(pend));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] txv(input int k);
    return 16'hA5A5 ^ 16'(k * 16'h0101);
  endfunction
  function automatic logic [15:0] rxv(input int k);
    return 16'h1000 + 16'(k * 7);
  endfunction
  function automatic logic [3:0] flv(input int k);
    return {k >= 28, k == 32, k <= 4, k == 0};
  endfunction

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk(tx_cnt == 0 && rx_cnt == 0, "R2 reset counts", {tx_cnt, rx_cnt}, 0);
    chk(tx_fl == 4'b0011 && rx_fl == 4'b0011, "R2 reset flags", {tx_fl, rx_fl}, 8'h33);
    chk(stat == 0 && !pend && !tx_dreq && !rx_dreq, "R8 reset status", stat, 0);
    chk(rx_rdata == 0 && !tx_sv, "R1 reset empty outputs", rx_rdata, 0);

    // fill sweep: every level against every watermark
    for (int k = 0; k <= 32; k++) begin
      for (int wm = 0; wm < 64; wm++) begin
        cyc();
        ctrl = 19'h67 | (19'(wm) << 13) | (19'(wm) << 7);
        #1;
        chk(tx_dreq == (k <= wm), "R4 tx request", tx_dreq, k <= wm);
        chk(rx_dreq == (k >= wm), "R5 rx request", rx_dreq, k >= wm);
      end
      chk(tx_cnt == 6'(k) && rx_cnt == 6'(k), "R2 count", {tx_cnt, rx_cnt}, {6'(k), 6'(k)});
      chk(tx_fl == flv(k) && rx_fl == flv(k), "R2 flags", {tx_fl, rx_fl}, {flv(k), flv(k)});
      if (k < 32) begin
        tx_wr = 1; tx_wd = txv(k); rx_wr = 1; rx_wd = rxv(k);
        cyc();
        tx_wr = 0; rx_wr = 0;
      end
    end

    ctrl = 19'h7;
    tx_wr = 1; tx_wd = 16'hDEAD; rx_wr = 1; rx_wd = 16'hBEEF;
    cyc();
    tx_wr = 0; rx_wr = 0;
    chk(tx_cnt == 32 && rx_cnt == 32, "R6 push on full dropped", {tx_cnt, rx_cnt}, {6'd32, 6'd32});
    chk(stat[5] && stat[11], "R6 overflow status", stat, 12'h820);

    for (int k = 0; k < 32; k++) begin
      chk(tx_sv && tx_sd == txv(k), "R1 tx order", tx_sd, txv(k));
      chk(rx_rdata == {1'b1, rxv(k)}, "R1 rx order", rx_rdata, {1'b1, rxv(k)});
      chk(tx_cnt == 6'(32 - k), "R2 drain count", tx_cnt, 32 - k);
      tx_req = 1; rx_rd = 1;
      cyc();
      tx_req = 0; rx_rd = 0;
    end
    chk(!tx_sv && rx_rdata[16] == 0, "R1 empty valid low", {tx_sv, rx_rdata[16]}, 0);
    tx_req = 1; rx_rd = 1;
    cyc();
    tx_req = 0; rx_rd = 0;
    chk(stat[4] && stat[10], "R7 starve status", stat, 12'h410);
    chk(stat == 12'hFFF, "R8 all events seen", stat, 12'hFFF);

    ctrl = 0;
    cyc();
    clr_we = 1; clr_mask = 12'h0F0;
    cyc();
    clr_we = 0;
    chk(stat == 12'hF0F, "R9 clear by mask", stat, 12'hF0F);

    for (int g = 0; g < 2; g++)
      for (int e = 0; e < 4096; e++) begin
        glb = g[0]; irq_en = 12'(e);
        #1;
        chk(pend == (g[0] && ((12'(e) & 12'hF0F) != 0)), "R10 pending", pend,
            g[0] && ((12'(e) & 12'hF0F) != 0));
      end

    ctrl = 19'h5; clr_we = 1; clr_mask = 12'hFC3;
    cyc();
    clr_we = 0;
    chk(stat == 12'h00F, "R9 set wins over clear", stat, 12'h00F);

    ctrl = 19'h7;
    tx_wr = 1;
    repeat (3) cyc();
    tx_wr = 0;
    chk(tx_cnt == 3, "R3 enabled push", tx_cnt, 3);
    ctrl = 19'h3;
    cyc();
    chk(tx_cnt == 0 && !tx_sv, "R3 disable empties", tx_cnt, 0);
    tx_wr = 1;
    cyc();
    tx_wr = 0;
    chk(tx_cnt == 0 && stat[5] == 0, "R3 push ignored while off", {tx_cnt, stat[5]}, 0);
    ctrl = 19'h2; rx_wr = 1;
    cyc();
    rx_wr = 0;
    chk(rx_cnt == 0 && rx_rdata == 0, "R3 global off blocks rx", rx_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule